// File: doc/BRIEF.md
# Amplifier Gain Fade Sequencer

This block steers the 5-bit gain code of a stereo power amplifier into and out of shutdown. It works on the system clock, and a slow single-cycle `tick` enable sets its time base. It also coordinates the shutdown sequence with an analog bias-reference monitor. That monitor reports whether the reference is fully charged or fully discharged, and the block drives enables that start charging or discharging it.

Two behaviours are selected by `fade_hold`. When `fade_hold` is low, the gain walks one level at a time, and each level lasts a fixed number of ticks (two by default). On shutdown it walks down to level 0 before the bias is discharged. On wake-up it walks back up to the target after the bias has charged. When `fade_hold` is high, shutdown stores the present gain and cuts the output at once. Wake-up then brings the stored gain back in a single cycle once the bias is charged.

The block has no data stream. Every port is a plain control or status level, with no valid/ready handshake, and the inputs are sampled on every clock edge. The next state is held in a six-state controller: ACTIVE, RAMP_DOWN, DISCHARGE, OFF, CHARGE and RAMP_UP.

Top module: `gain_fade_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the off state. In that state `gain_code` is 0, `mute`=1, `low_power`=1, `bias_chg_en`=0 and `bias_dischg_en`=0, and the stored gain is cleared.
- R2: With `fade_hold`=0 and `shdn_n`=0, `gain_code` drops by exactly one level on every second `tick` until it is 0. A full descent from 31 takes 62 ticks.
- R3: `bias_dischg_en` is asserted only while `gain_code` is 0, and it stays high until `bias_discharged`=1. After that the block rests with `mute`=1 and `low_power`=1, and both enables are low.
- R4: When `shdn_n` goes high from the off state, `bias_chg_en`=1 and `mute`=1 hold, and `gain_code` stays 0 whatever ticks arrive, until `bias_charged`=1.
- R5: With `fade_hold`=0, once the bias is charged, `gain_code` rises by one level on every second `tick` until it equals `target_gain`. During the rise `mute`=0.
- R6: With `fade_hold`=1, asserting `shdn_n`=0 from the running state gives `gain_code`=0, `mute`=1 and `bias_dischg_en`=1 one clock later, with no ramp. The gain held before that edge is stored.
- R7: With `fade_hold`=1, one clock after `bias_charged`=1 is seen in the charge phase, `gain_code` equals the stored gain in a single jump, regardless of `target_gain`, and `mute`=0.
- R8: If `shdn_n` returns high during a descent, `gain_code` climbs back toward `target_gain` from the level it had reached. It does not fall to 0 and no bias charge phase occurs.
- R9: A change of `target_gain` while running moves `gain_code` toward the new value at one level per two ticks, in either direction.
- R10: Outside the muted phases, `gain_code` changes only in the cycle after a `tick`, and only by one level.
- R11: `bias_chg_en` and `bias_dischg_en` are never high together, and `low_power`=1 implies `mute`=1 and `gain_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle time-base enable |
| shdn_n | input | 1 | Shutdown request, active low |
| fade_hold | input | 1 | 0: ramped fade, 1: store and restore |
| target_gain | input | 5 | Requested gain level, 0 to 31, 2 dB per level |
| bias_charged | input | 1 | Bias reference has reached its working level |
| bias_discharged | input | 1 | Bias reference has reached ground |
| gain_code | output | 5 | Present gain level |
| mute | output | 1 | Output muted |
| bias_dischg_en | output | 1 | Enable bias reference discharge |
| bias_chg_en | output | 1 | Enable bias reference charge |
| low_power | output | 1 | Block is resting in shutdown |

## Verification
The hardest case to reach from the ports is the reversal in the middle of a descent. Here `shdn_n` must rise while the controller is still stepping down and the tick phase is half-way through a step. The bench first ramps the gain to a known level and starts a ramped shutdown. It then issues an exact number of ticks so that the level is known and 0 has not been reached, and releases `shdn_n` there. From that point it counts ticks to predict each upward step, and it confirms that the bias charge enable never rises. The stored-gain path is checked with a target that differs from the stored value, which shows that the restore ignores the target.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_RAMP_DOWN = 3'd1,
    ST_DISCHARGE = 3'd2,
    ST_OFF       = 3'd3,
    ST_CHARGE    = 3'd4,
    ST_RAMP_UP   = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_TRACK   = 3'd1,
    OP_FALL    = 3'd2,
    OP_CUT     = 3'd3,
    OP_RESTORE = 3'd4
  } gain_op_e;

endpackage

// File: rtl/gfs_step_div.sv
// Turns the slow tick into a step strobe: one step per TICKS_PER_STEP
// ticks while run is high; the phase restarts whenever run drops.
module gfs_step_div #(
  parameter int TICKS_PER_STEP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic step
);
  localparam int CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (tick) begin
      if (phase_q == LAST) phase_q <= '0;
      else                 phase_q <= phase_q + 1'b1;
    end
  end

  assign step = run && tick && (phase_q == LAST);

endmodule

// File: rtl/gfs_gain_unit.sv
// Holds the live gain level and the level saved for a store-and-restore
// shutdown; applies one operation per cycle as chosen by the controller.
module gfs_gain_unit
  import gfs_pkg::*;
#(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  gain_op_e      op,
  input  logic          step,
  input  logic [GW-1:0] target,
  output logic [GW-1:0] gain,
  output logic [GW-1:0] saved
);
  logic [GW-1:0] gain_q, saved_q;
  logic [GW-1:0] gain_d, saved_d;

  always_comb begin
    gain_d  = gain_q;
    saved_d = saved_q;
    unique case (op)
      OP_TRACK: begin
        if (step) begin
          if (gain_q < target)      gain_d = gain_q + 1'b1;
          else if (gain_q > target) gain_d = gain_q - 1'b1;
        end
      end
      OP_FALL: begin
        if (step && gain_q != '0) gain_d = gain_q - 1'b1;
      end
      OP_CUT: begin
        saved_d = gain_q;
        gain_d  = '0;
      end
      OP_RESTORE: gain_d = saved_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q  <= '0;
      saved_q <= '0;
    end else begin
      gain_q  <= gain_d;
      saved_q <= saved_d;
    end
  end

  assign gain  = gain_q;
  assign saved = saved_q;

endmodule

// File: rtl/gfs_ctrl.sv
// Sequencing controller: state register, gain operation select, step
// run enable and the decoded status outputs.
module gfs_ctrl
  import gfs_pkg::*;
#(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shdn_n,
  input  logic          fade_hold,
  input  logic          bias_charged,
  input  logic          bias_discharged,
  input  logic [GW-1:0] gain,
  input  logic [GW-1:0] target,
  output gain_op_e      op,
  output logic          run,
  output logic          mute,
  output logic          chg_en,
  output logic          dischg_en,
  output logic          low_power
);
  seq_state_e state_q, state_d;
  logic at_target, at_floor;

  assign at_target = (gain == target);
  assign at_floor  = (gain == '0);

  always_comb begin
    state_d = state_q;
    op      = OP_HOLD;
    run     = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (!shdn_n) begin
          if (fade_hold) begin
            op      = OP_CUT;
            state_d = ST_DISCHARGE;
          end else begin
            state_d = ST_RAMP_DOWN;
          end
        end else begin
          op  = OP_TRACK;
          run = !at_target;
        end
      end
      ST_RAMP_DOWN: begin
        if (shdn_n) begin
          state_d = ST_RAMP_UP;
          run     = 1'b1;
        end else if (at_floor) begin
          state_d = ST_DISCHARGE;
        end else begin
          op  = OP_FALL;
          run = 1'b1;
        end
      end
      ST_DISCHARGE: begin
        if (shdn_n)               state_d = ST_CHARGE;
        else if (bias_discharged) state_d = ST_OFF;
      end
      ST_OFF: begin
        if (shdn_n) state_d = ST_CHARGE;
      end
      ST_CHARGE: begin
        if (!shdn_n) begin
          state_d = ST_DISCHARGE;
        end else if (bias_charged) begin
          if (fade_hold) begin
            op      = OP_RESTORE;
            state_d = ST_ACTIVE;
          end else begin
            state_d = ST_RAMP_UP;
          end
        end
      end
      ST_RAMP_UP: begin
        if (!shdn_n) begin
          if (fade_hold) begin
            op      = OP_CUT;
            state_d = ST_DISCHARGE;
          end else begin
            state_d = ST_RAMP_DOWN;
            run     = 1'b1;
          end
        end else if (at_target) begin
          state_d = ST_ACTIVE;
        end else begin
          op  = OP_TRACK;
          run = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_d;
  end

  always_comb begin
    mute      = (state_q == ST_DISCHARGE) || (state_q == ST_OFF) || (state_q == ST_CHARGE);
    chg_en    = (state_q == ST_CHARGE);
    dischg_en = (state_q == ST_DISCHARGE);
    low_power = (state_q == ST_OFF);
  end

endmodule

// File: rtl/gain_fade_seq.sv
module gain_fade_seq
  import gfs_pkg::*;
#(
  parameter int GW             = 5,
  parameter int TICKS_PER_STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          shdn_n,
  input  logic          fade_hold,
  input  logic [GW-1:0] target_gain,
  input  logic          bias_charged,
  input  logic          bias_discharged,
  output logic [GW-1:0] gain_code,
  output logic          mute,
  output logic          bias_dischg_en,
  output logic          bias_chg_en,
  output logic          low_power
);
  gain_op_e      op;
  logic          run, step;
  logic [GW-1:0] gain, saved;

  gfs_ctrl #(.GW(GW)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .shdn_n          (shdn_n),
    .fade_hold       (fade_hold),
    .bias_charged    (bias_charged),
    .bias_discharged (bias_discharged),
    .gain            (gain),
    .target          (target_gain),
    .op              (op),
    .run             (run),
    .mute            (mute),
    .chg_en          (bias_chg_en),
    .dischg_en       (bias_dischg_en),
    .low_power       (low_power)
  );

  gfs_step_div #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (run),
    .step (step)
  );

  gfs_gain_unit #(.GW(GW)) u_gain (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .step   (step),
    .target (target_gain),
    .gain   (gain),
    .saved  (saved)
  );

  assign gain_code = gain;

endmodule

// File: rtl/gfs_checker.sv
module gfs_checker #(
  parameter int GW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [GW-1:0] gain_code,
  input logic          mute,
  input logic          bias_chg_en,
  input logic          bias_dischg_en,
  input logic          low_power
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R10: unmuted gain moves only after a tick, and by one level
  p_step_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (primed && !mute && !$past(mute) && gain_code != $past(gain_code))
      |-> ($past(tick) &&
           (gain_code == $past(gain_code) + 1'b1 || gain_code == $past(gain_code) - 1'b1)));

  // R11: charge and discharge are exclusive
  p_excl_enables_r11: assert property (@(posedge clk) disable iff (rst)
    !(bias_chg_en && bias_dischg_en));

  // R11: resting shutdown is muted at level 0
  p_lowpow_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    low_power |-> (mute && gain_code == '0));

  // R3: discharge only at the floor level
  p_dischg_floor_r3: assert property (@(posedge clk) disable iff (rst)
    bias_dischg_en |-> (gain_code == '0 && mute));

  // R4: charging keeps the gain at 0 and muted
  p_chg_floor_r4: assert property (@(posedge clk) disable iff (rst)
    bias_chg_en |-> (gain_code == '0 && mute));

  // R4: the gain does not leave 0 while the charge phase continues
  p_chg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && bias_chg_en && $past(bias_chg_en)) |-> $stable(gain_code));

endmodule

bind gain_fade_seq gfs_checker #(.GW(GW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick           (tick),
  .gain_code      (gain_code),
  .mute           (mute),
  .bias_chg_en    (bias_chg_en),
  .bias_dischg_en (bias_dischg_en),
  .low_power      (low_power)
);

// File: tb/gain_fade_seq_tb.sv
`timescale 1ns/1ps
module gain_fade_seq_tb;
  logic       clk = 1'b0;
  logic       rst, tick, shdn_n, fade_hold, bias_charged, bias_discharged;
  logic [4:0] target_gain, gain_code;
  logic       mute, bias_dischg_en, bias_chg_en, low_power;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  gain_fade_seq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .shdn_n(shdn_n), .fade_hold(fade_hold),
    .target_gain(target_gain), .bias_charged(bias_charged),
    .bias_discharged(bias_discharged), .gain_code(gain_code), .mute(mute),
    .bias_dischg_en(bias_dischg_en), .bias_chg_en(bias_chg_en), .low_power(low_power)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // each tick: one cycle high, then two quiet cycles
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick = 1'b0; shdn_n = 1'b0; fade_hold = 1'b0;
    target_gain = 5'd31; bias_charged = 1'b0; bias_discharged = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1 gain", gain_code, 0);
    chk("R1 mute", mute, 1);
    chk("R1 low_power", low_power, 1);
    chk("R1 chg_en", bias_chg_en, 0);
    chk("R1 dischg_en", bias_dischg_en, 0);
  endtask

  task automatic t_wake_ramp();
    shdn_n = 1'b1; bias_discharged = 1'b0;
    wait_cyc(1);
    chk("R4 chg_en", bias_chg_en, 1);
    ticks(4);
    chk("R4 gain held", gain_code, 0);
    chk("R4 mute", mute, 1);
    bias_charged = 1'b1;
    wait_cyc(1);
    chk("R4 chg_en off", bias_chg_en, 0);
    ticks(1);
    chk("R5 half step", gain_code, 0);
    ticks(1);
    chk("R5 first step", gain_code, 1);
    chk("R5 unmuted", mute, 0);
    ticks(60);
    chk("R5 top", gain_code, 31);
    ticks(2);
    chk("R5 stays at target", gain_code, 31);
  endtask

  task automatic t_ramp_down();
    shdn_n = 1'b0;
    wait_cyc(1);
    ticks(2);
    chk("R2 one level", gain_code, 30);
    ticks(59);
    chk("R2 level after 61 ticks", gain_code, 1);
    chk("R3 no discharge above 0", bias_dischg_en, 0);
    ticks(1);
    chk("R2 floor after 62 ticks", gain_code, 0);
    chk("R3 discharge", bias_dischg_en, 1);
    bias_charged = 1'b0;
    wait_cyc(4);
    chk("R3 waits for flag", bias_dischg_en, 1);
    bias_discharged = 1'b1;
    wait_cyc(2);
    chk("R3 discharge off", bias_dischg_en, 0);
    chk("R3 low_power", low_power, 1);
    chk("R3 mute", mute, 1);
  endtask

  task automatic t_reverse();
    int peak_chg = 0;
    target_gain = 5'd10;
    shdn_n = 1'b1; bias_discharged = 1'b0;
    wait_cyc(2);
    bias_charged = 1'b1;
    wait_cyc(1);
    ticks(20);
    chk("R5 reach 10", gain_code, 10);
    shdn_n = 1'b0;
    wait_cyc(1);
    ticks(6);
    chk("R8 partial descent", gain_code, 7);
    shdn_n = 1'b1;
    wait_cyc(1);
    for (int i = 0; i < 2; i++) begin
      ticks(1);
      if (bias_chg_en) peak_chg = 1;
    end
    chk("R8 climbs from 7", gain_code, 8);
    ticks(4);
    chk("R8 back at target", gain_code, 10);
    chk("R8 no charge phase", peak_chg | bias_chg_en, 0);
  endtask

  task automatic t_target_change();
    target_gain = 5'd13;
    ticks(1);
    chk("R9 half step", gain_code, 10);
    ticks(1);
    chk("R9 up one", gain_code, 11);
    ticks(4);
    chk("R9 up to 13", gain_code, 13);
    target_gain = 5'd12;
    ticks(2);
    chk("R9 down one", gain_code, 12);
  endtask

  task automatic t_store_restore();
    fade_hold = 1'b1;
    shdn_n = 1'b0;
    wait_cyc(1);
    chk("R6 cut", gain_code, 0);
    chk("R6 mute", mute, 1);
    chk("R6 discharge", bias_dischg_en, 1);
    bias_charged = 1'b0; bias_discharged = 1'b1;
    wait_cyc(2);
    chk("R3 off after discharge", low_power, 1);
    target_gain = 5'd3;
    shdn_n = 1'b1; bias_discharged = 1'b0;
    wait_cyc(2);
    chk("R4 charging", bias_chg_en, 1);
    chk("R4 gain zero", gain_code, 0);
    bias_charged = 1'b1;
    wait_cyc(1);
    chk("R7 restored", gain_code, 12);
    chk("R7 unmuted", mute, 0);
  endtask

  initial begin
    t_reset();
    t_wake_ramp();
    t_ramp_down();
    t_reverse();
    t_target_change();
    t_store_restore();
    wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule